// File: doc/BRIEF.md
# Aligned Range Invalidate Sequencer

This block takes a request to invalidate a byte address range in a data cache, given as a start and an end address. It covers that range with a short series of naturally aligned power-of-two chunks rather than stepping one line at a time. For each chunk it drives a mask word and a command word to a separate purge engine, with a one-cycle write strobe. It then waits for the engine's busy input to fall before it moves on.

The chunk size follows two rules. It is never larger than the alignment of the current address, and never larger than the bytes still left. Large, well-aligned ranges therefore take only a few commands. A range that is poorly aligned at its start grows its chunks step by step as the address picks up alignment. Requests use a valid/ready handshake, and a one-cycle done pulse marks the end of each request.

Top module: `range_inval_seq`

## Requirements
- R1: If `cache_en_i` is low when a request is accepted, `done_o` pulses in the cycle after acceptance and no command strobe is issued.
- R2: The start address is rounded down and the end address rounded up to a multiple of `LINE_BYTES` (default 16) before chunking. For example, 0x1003..0x1005 becomes a single 16-byte chunk at 0x1000.
- R3: The command strobe is never raised while the busy input was high in the cycle before, so the first chunk waits for a busy engine to go idle.
- R4: Each command address is a multiple of its own chunk size.
- R5: The alignment of a nonzero address is its largest power-of-two divisor, and at address zero the remaining size is used in its place. The chunk equals that alignment when the remaining size is larger than it. Otherwise the chunk is the largest power of two not above the remaining size.
- R6: The mask equals the bitwise inverse of (chunk size minus one), and the chunk is never smaller than one line.
- R7: The command word is the chunk address ORed with an invalidate bit at position `INV_BIT` (default bit 0).
- R8: After each command the block waits for busy to fall. The next chunk starts at the previous address plus the previous chunk size, and the sequence stops once the address reaches the rounded end.
- R9: `done_o` is a one-cycle pulse that follows the falling busy of the last chunk, and the block is ready again in that cycle.
- R10: A request presented while a sequence is in progress is ignored and issues no command.
- R11: A range that is empty after rounding completes with a done pulse in the next cycle and no command.
- R12: After reset the block is ready, with `done_o` and the strobe low, and the strobe is high for exactly one cycle per chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en_i | input | 1 | Data cache enabled |
| req_valid_i | input | 1 | Range request valid |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_start_i | input | ADDR_W | First byte address of the range |
| req_end_i | input | ADDR_W | Address just past the range |
| done_o | output | 1 | One-cycle completion pulse |
| pg_busy_i | input | 1 | Purge engine busy |
| pg_cmd_we_o | output | 1 | Write strobe for mask and command |
| pg_mask_o | output | ADDR_W | Chunk mask |
| pg_cmd_o | output | ADDR_W | Chunk address with invalidate bit |

## Verification
The bench goes after ranges that start badly aligned, ranges that start at address zero, and ranges whose size is not a power of two. A wrong alignment or size rule would show up there as a chunk that crosses its own boundary or that runs past the end. Sub-line ranges test the rounding, since a design that truncates the end instead of rounding it up would report an empty range and issue nothing. Holding busy high at request time catches a design that writes the first command while the engine is still busy. A second request sent in the middle of a sequence catches one that restarts or chains onto it. Disabled and empty requests must finish in one cycle with no strobe.

// File: rtl/rinv_pkg.sv
package rinv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_WAIT   = 2'd3
    } rinv_state_e;

endpackage

// File: rtl/rinv_round.sv
// Rounds a request outward to whole cache lines and reports its length.
module rinv_round #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] end_o,
    output logic [ADDR_W-1:0] len_o,
    output logic              empty_o
);
    localparam logic [ADDR_W-1:0] LINE_M1 = ADDR_W'(LINE_BYTES - 1);

    always_comb begin
        start_o = start_i & ~LINE_M1;
        end_o   = (end_i + LINE_M1) & ~LINE_M1;
        empty_o = (end_o <= start_o);
        len_o   = empty_o ? '0 : (end_o - start_o);
    end
endmodule

// File: rtl/rinv_align.sv
// Alignment of the current address; zero address falls back to the remainder.
module rinv_align #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] rem_i,
    output logic [ADDR_W-1:0] align_o
);
    localparam logic [ADDR_W-1:0] LINE_M1 = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] line_addr;

    always_comb begin
        line_addr = addr_i & ~LINE_M1;
        if (line_addr == '0) begin
            align_o = rem_i;
        end else begin
            align_o = line_addr & (~line_addr + 1'b1);
        end
    end
endmodule

// File: rtl/rinv_chunk.sv
// Picks the chunk: alignment if the remainder exceeds it, else the top power of two of the remainder.
module rinv_chunk #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] rem_i,
    input  logic [ADDR_W-1:0] align_i,
    output logic [ADDR_W-1:0] chunk_o
);
    logic [ADDR_W-1:0] top_pow2;

    always_comb begin
        top_pow2 = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (rem_i[i]) top_pow2 = ADDR_W'(1) << i;
        end
        chunk_o = (rem_i > align_i) ? align_i : top_pow2;
    end
endmodule

// File: rtl/rinv_cmd.sv
// Formats the mask and command words for one chunk.
module rinv_cmd #(
    parameter int ADDR_W  = 32,
    parameter int INV_BIT = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] chunk_i,
    output logic [ADDR_W-1:0] mask_o,
    output logic [ADDR_W-1:0] cmd_o
);
    localparam logic [ADDR_W-1:0] INV_FLAG = ADDR_W'(1) << INV_BIT;

    always_comb begin
        mask_o = ~(chunk_i - 1'b1);
        cmd_o  = (addr_i & mask_o) | INV_FLAG;
    end
endmodule

// File: rtl/range_inval_seq.sv
module range_inval_seq
    import rinv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int INV_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_start_i,
    input  logic [ADDR_W-1:0] req_end_i,
    output logic              done_o,
    input  logic              pg_busy_i,
    output logic              pg_cmd_we_o,
    output logic [ADDR_W-1:0] pg_mask_o,
    output logic [ADDR_W-1:0] pg_cmd_o
);
    localparam int LINE_LOG2 = $clog2(LINE_BYTES);

    typedef struct packed {
        rinv_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] end_a;
        logic [ADDR_W-1:0] rem;
        logic [ADDR_W-1:0] chunk;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] cmd;
    } seq_s;

    seq_s seq_q, seq_d;

    logic [ADDR_W-1:0] rnd_start, rnd_end, rnd_len;
    logic              rnd_empty;
    logic [ADDR_W-1:0] align_w, chunk_w, mask_w, cmd_w;
    logic [ADDR_W-1:0] next_addr;

    rinv_round #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_round (
        .start_i (req_start_i),
        .end_i   (req_end_i),
        .start_o (rnd_start),
        .end_o   (rnd_end),
        .len_o   (rnd_len),
        .empty_o (rnd_empty)
    );

    rinv_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
        .addr_i  (seq_q.addr),
        .rem_i   (seq_q.rem),
        .align_o (align_w)
    );

    rinv_chunk #(.ADDR_W(ADDR_W)) u_chunk (
        .rem_i   (seq_q.rem),
        .align_i (align_w),
        .chunk_o (chunk_w)
    );

    rinv_cmd #(.ADDR_W(ADDR_W), .INV_BIT(INV_BIT)) u_cmd (
        .addr_i  (seq_q.addr),
        .chunk_i (chunk_w),
        .mask_o  (mask_w),
        .cmd_o   (cmd_w)
    );

    assign next_addr = seq_q.addr + seq_q.chunk;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.we   = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (!cache_en_i || rnd_empty) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st    = ST_ISSUE;
                        seq_d.addr  = rnd_start;
                        seq_d.end_a = rnd_end;
                        seq_d.rem   = rnd_len;
                    end
                end
            end
            ST_ISSUE: begin
                if (!pg_busy_i) begin
                    seq_d.we    = 1'b1;
                    seq_d.mask  = mask_w;
                    seq_d.cmd   = cmd_w;
                    seq_d.chunk = chunk_w;
                    seq_d.st    = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                seq_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (!pg_busy_i) begin
                    seq_d.addr = next_addr;
                    seq_d.rem  = seq_q.rem - seq_q.chunk;
                    if (next_addr < seq_q.end_a) begin
                        seq_d.st = ST_ISSUE;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready_o = (seq_q.st == ST_IDLE);
    assign done_o      = seq_q.done;
    assign pg_cmd_we_o = seq_q.we;
    assign pg_mask_o   = seq_q.mask;
    assign pg_cmd_o    = seq_q.cmd;

    if (LINE_LOG2 < 1 || (1 << LINE_LOG2) != LINE_BYTES || INV_BIT >= LINE_LOG2) begin : g_bad_cfg
        initial $error("range_inval_seq: LINE_BYTES must be a power of two above INV_BIT");
    end
endmodule

// File: rtl/rinv_checker.sv
module rinv_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int INV_BIT    = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cache_en_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              done_o,
    input logic              pg_busy_i,
    input logic              pg_cmd_we_o,
    input logic [ADDR_W-1:0] pg_mask_o,
    input logic [ADDR_W-1:0] pg_cmd_o
);
    localparam logic [ADDR_W-1:0] LINE_M1  = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] INV_FLAG = ADDR_W'(1) << INV_BIT;

    logic [ADDR_W-1:0] size_seen;
    assign size_seen = ~pg_mask_o + 1'b1;

    p_disabled_no_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !cache_en_i) |=> (done_o && !pg_cmd_we_o));

    p_strobe_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pg_cmd_we_o |-> !$past(pg_busy_i));

    p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pg_cmd_we_o |-> ((pg_cmd_o & ~pg_mask_o) == INV_FLAG));

    p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_cmd_we_o |-> (($countones(size_seen) == 1) && ((pg_mask_o & LINE_M1) == '0)));

    p_inv_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pg_cmd_we_o |-> pg_cmd_o[INV_BIT]);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready_o);

    p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pg_cmd_we_o |=> !pg_cmd_we_o);

    p_busy_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pg_cmd_we_o |-> !req_ready_o);
endmodule

bind range_inval_seq rinv_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .INV_BIT(INV_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cache_en_i(cache_en_i), .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o), .done_o(done_o), .pg_busy_i(pg_busy_i),
    .pg_cmd_we_o(pg_cmd_we_o), .pg_mask_o(pg_mask_o), .pg_cmd_o(pg_cmd_o)
);

// File: tb/tb_range_inval_seq.sv
`timescale 1ns/1ps
module tb_range_inval_seq;
    localparam int LINE = 16;
    localparam int NV   = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_start = '0;
    logic [31:0] req_end = '0;
    logic        req_ready, done, pg_we;
    logic [31:0] pg_mask, pg_cmd;
    logic        eng_busy = 1'b0;
    logic        hold_busy = 1'b0;
    int          eng_cnt = 0;
    int          eng_lat = 2;
    logic        pg_busy;

    int n_chk = 0, n_fail = 0;
    logic [31:0] log_cmd [64];
    logic [31:0] log_mask[64];
    int          log_n = 0;
    logic        log_clr = 1'b0;
    logic [31:0] exp_addr [64];
    logic [31:0] exp_chunk[64];
    int          exp_n;
    int          cyc;

    localparam logic [31:0] V_START[NV] = '{32'h1010, 32'h0, 32'h1003, 32'h2000, 32'h3000,
        32'h0, 32'h0FF0, 32'h12345678, 32'h1008, 32'h40000000, 32'h10};
    localparam logic [31:0] V_END[NV] = '{32'h1100, 32'h100, 32'h1005, 32'h2000, 32'h4000,
        32'h130, 32'h1020, 32'h12345679, 32'h1008, 32'h40010000, 32'h10000};
    localparam bit V_EN[NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 1};
    localparam int V_CNT[NV] = '{4, 1, 1, 0, 0, 3, 2, 1, 1, 1, 12};
    localparam int V_LAT[NV] = '{0, 3, 1, 2, 2, 5, 0, 1, 4, 2, 1};

    assign pg_busy = eng_busy | hold_busy;

    always #2 clk = ~clk;

    range_inval_seq dut (
        .clk(clk), .rst_n(rst_n), .cache_en_i(cache_en), .req_valid_i(req_valid),
        .req_ready_o(req_ready), .req_start_i(req_start), .req_end_i(req_end),
        .done_o(done), .pg_busy_i(pg_busy), .pg_cmd_we_o(pg_we),
        .pg_mask_o(pg_mask), .pg_cmd_o(pg_cmd)
    );

    // purge engine model: busy from the edge after the strobe for eng_lat more cycles
    always @(posedge clk) begin
        if (pg_we) begin
            eng_busy <= 1'b1;
            eng_cnt  <= eng_lat;
        end else if (eng_cnt > 0) begin
            eng_cnt <= eng_cnt - 1;
        end else begin
            eng_busy <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (log_clr) begin
            log_n <= 0;
        end else if (rst_n && pg_we && log_n < 64) begin
            log_cmd[log_n]  <= pg_cmd;
            log_mask[log_n] <= pg_mask;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] s, input logic [31:0] e, input bit en);
        bit [63:0] a, fin, rem, al, ch, p;
        exp_n = 0;
        if (!en) return;
        a   = {32'h0, s} - ({32'h0, s} % LINE);
        fin = ({32'h0, e} % LINE == 0) ? {32'h0, e} : {32'h0, e} + LINE - ({32'h0, e} % LINE);
        while (a < fin && exp_n < 64) begin
            rem = fin - a;
            if (a == 0) al = rem;
            else begin
                al = LINE;
                while (a % (al * 2) == 0) al = al * 2;
            end
            if (rem > al) ch = al;
            else begin
                p = 1;
                while (p * 2 <= rem) p = p * 2;
                ch = p;
            end
            exp_addr[exp_n]  = a[31:0];
            exp_chunk[exp_n] = ch[31:0];
            exp_n++;
            a = a + ch;
        end
    endtask

    task automatic clear_log();
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
    endtask

    task automatic send(input logic [31:0] s, input logic [31:0] e, input bit en);
        @(negedge clk);
        cache_en  = en;
        req_start = s;
        req_end   = e;
        req_valid = 1'b1;
    endtask

    task automatic wait_done();
        cyc = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
        end while (!done && cyc < 5000);
    endtask

    task automatic compare_log(input string req);
        check(log_n == exp_n, {req, " command count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check(log_cmd[i] === (exp_addr[i] | 32'h1), {req, " command word"}, log_cmd[i], exp_addr[i] | 32'h1);
            check(log_mask[i] === ~(exp_chunk[i] - 32'h1), {req, " mask"}, log_mask[i], ~(exp_chunk[i] - 32'h1));
        end
    endtask

    initial begin
        #600000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(req_ready === 1'b1, "R12 ready after reset", req_ready, 1);
        check(done === 1'b0, "R12 done after reset", done, 0);
        check(pg_we === 1'b0, "R12 strobe after reset", pg_we, 0);

        // vector table: R2 R4 R5 R6 R7 R8 R9 R1 R11
        for (int v = 0; v < NV; v++) begin
            eng_lat = V_LAT[v];
            clear_log();
            model(V_START[v], V_END[v], V_EN[v]);
            check(exp_n == V_CNT[v], "R5 bench model count", exp_n, V_CNT[v]);
            send(V_START[v], V_END[v], V_EN[v]);
            wait_done();
            check(done === 1'b1, "R9 done seen", done, 1);
            check(req_ready === 1'b1, "R9 ready with done", req_ready, 1);
            @(negedge clk);
            check(done === 1'b0, "R9 done one cycle", done, 0);
            compare_log("R5 R8 sequence");
            if (V_CNT[v] == 0) begin
                check(cyc == 1, "R1 R11 immediate done", cyc, 1);
            end
        end

        // R2: sub-line range rounded to one line at 0x1000
        eng_lat = 1;
        clear_log();
        send(32'h1003, 32'h1005, 1'b1);
        wait_done();
        check(log_n == 1 && log_cmd[0] == 32'h1001, "R2 rounding", log_cmd[0], 32'h1001);
        check(log_mask[0] == 32'hFFFF_FFF0, "R6 line mask", log_mask[0], 32'hFFFF_FFF0);

        // R3: engine busy at request time delays the first command
        clear_log();
        hold_busy = 1'b1;
        send(32'h5000, 32'h5040, 1'b1);
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        check(log_n == 0, "R3 no command while busy", log_n, 0);
        check(req_ready === 1'b0, "R3 sequence pending", req_ready, 0);
        hold_busy = 1'b0;
        wait_done();
        model(32'h5000, 32'h5040, 1'b1);
        compare_log("R3 after release");

        // R10: second request during a sequence is ignored
        eng_lat = 3;
        clear_log();
        send(32'h0FF0, 32'h1020, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_start = 32'h8000;
        req_end   = 32'h9000;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        model(32'h0FF0, 32'h1020, 1'b1);
        compare_log("R10 ignore while busy");
        repeat (20) @(negedge clk);
        check(log_n == 2, "R10 no extra commands", log_n, 2);
        check(req_ready === 1'b1, "R10 idle afterwards", req_ready, 1);

        // R1: disabled cache with a large range
        clear_log();
        send(32'h0, 32'h10000, 1'b0);
        wait_done();
        check(cyc == 1 && log_n == 0, "R1 disabled no command", log_n, 0);

        // R11: end below start
        clear_log();
        send(32'h3000, 32'h2000, 1'b1);
        wait_done();
        check(cyc == 1 && log_n == 0, "R11 empty range", log_n, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule